// File: doc/BRIEF.md
# Ordered Predicated Floating-Point Lane Fold

This block takes a scalar floating-point start value and a vector register, and adds the vector's enabled lanes into the scalar. It works one lane per clock, always from lane 0 up to the highest lane. Because the order is fixed, the rounding of every intermediate sum is the same on every run, which a tree-shaped reduction cannot promise. A two-bit size code picks the element format at run time: half, single or double precision. A predicate with one bit per vector byte decides which lanes take part.

A request is taken with a one-cycle `start_i` pulse, which captures every operand. While the block works, `busy_o` stays high. When the last lane has been visited, `done_o` pulses and `result_o` carries the new scalar, which is meant to be written back over the start operand's register.

A request can be rejected. This happens if the size code is reserved, or if streaming mode is on while the full-feature enable is off. A rejected request raises `illegal_o` for one cycle instead and leaves the held result alone.

The built-in adder has these properties:
- It rounds to nearest-even.
- It flushes subnormal inputs and subnormal results to signed zero.
- It replaces any NaN outcome with the canonical quiet NaN.

Top module: `ordered_fp_fold`

## Requirements
- R1: The size code selects the element format. Code 01 is binary16, 10 is binary32 and 11 is binary64. The element width is 8<<code bits, and the lane count is VEC_W divided by that width. Elements are packed from bit 0 upward, lane k at bits [k*w +: w]. A result sits in the low w bits of `result_o`, and the upper bits are zero.
- R2: A start with size code 00 pulses `illegal_o` in the cycle after the start. In that case `busy_o` stays low and `result_o` keeps its value.
- R3: A start with `streaming_i`=1 and `fullfeat_i`=0 is illegal, and is handled as in R2. With `fullfeat_i`=1, streaming mode is legal.
- R4: Lane k is active when predicate bit k*(w/8) is set. All other predicate bits have no effect on the result.
- R5: The result is built as (((seed + e0) + e1) + ...) over the active lanes, in ascending lane order. Each addition is rounded to nearest-even in the selected format.
- R6: When no lane is active, the result equals the seed's low w bits unchanged, including NaN payloads.
- R7: After a legal start, `busy_o` is high for exactly as many cycles as there are lanes. `done_o` pulses in the first cycle with `busy_o` low again, and `result_o` is valid then. A start received while busy is ignored.
- R8: An operand with a zero exponent field is treated as a zero of its own sign. A sum whose rounded exponent falls below the normal range becomes a zero with the sign of the sum.
- R9: Three special cases apply:
  - A NaN operand, or infinities of opposite sign, gives the canonical quiet NaN: sign 0, exponent all ones, and only the top fraction bit set.
  - A finite sum above the largest finite value gives an infinity of the sum's sign.
  - An infinity plus a finite value keeps that infinity.
- R10: `result_o` holds its value through idle cycles and rejected requests until the next legal completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse; captures all operands when idle |
| seed_i | input | 64 | Scalar start value (low w bits used) |
| vec_i | input | VEC_W | Vector operand, lane 0 in the low bits |
| pred_i | input | VEC_W/8 | Predicate, one bit per vector byte |
| size_i | input | 2 | Element size code |
| streaming_i | input | 1 | Streaming mode is active |
| fullfeat_i | input | 1 | Full feature set enabled in streaming mode |
| busy_o | output | 1 | A fold is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle rejection pulse |
| result_o | output | 64 | Folded scalar, held until the next completion |

## Verification
The hardest situation to reach from the ports is strict ordering mattering for the result. Two lanes must cancel, or nearly cancel, around a third lane, so that a different association would round differently. The bench sweeps every active-lane mask for every size on a 128-bit vector, with random operands whose exponents lie in a narrow band. This reaches many partial-cancellation orders. Each result is compared against a model that adds in double precision and rounds to the target format independently. Junk bits are placed in the unused predicate positions on every run. Directed cases then target the remaining corners:
- flush to zero, including a negative subnormal difference;
- overflow to infinity;
- infinity minus infinity;
- an untouched NaN seed when no lane is active;
- a second start while busy.

// File: rtl/fold_pkg.sv
`timescale 1ns/1ps
// fold_pkg: size codes and a combinational floating-point adder shared by
// the fold unit. Assumes IEEE interchange encodings in the low bits of a
// 64-bit word; upper bits of inputs are ignored, those of results are zero.
package fold_pkg;

    typedef enum logic [1:0] {
        SZ_RSV = 2'b00,
        SZ_H   = 2'b01,
        SZ_S   = 2'b10,
        SZ_D   = 2'b11
    } size_t;

    // Exponent field width for a size code
    function automatic int exp_w(input logic [1:0] sz);
        return (sz == SZ_H) ? 5 : (sz == SZ_S) ? 8 : 11;
    endfunction

    // Fraction field width for a size code
    function automatic int frac_w(input logic [1:0] sz);
        return (sz == SZ_H) ? 10 : (sz == SZ_S) ? 23 : 52;
    endfunction

    // Mask covering one element of the given size
    function automatic logic [63:0] elem_mask(input logic [1:0] sz);
        return (sz == SZ_D) ? {64{1'b1}} : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    // Assemble sign, exponent and fraction fields
    function automatic logic [63:0] fp_pack(input logic [1:0] sz, input logic s,
                                            input int e, input logic [63:0] f);
        int ew;
        int fw;
        ew = exp_w(sz);
        fw = frac_w(sz);
        return (64'(s) << (ew + fw)) | (64'(e) << fw) | f;
    endfunction

    // Round-to-nearest-even addition with flush-to-zero and canonical NaN
    function automatic logic [63:0] fp_add(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] sz);
        int ew, fw, p, emax, lz, ea, eb, ex, ey, d, er;
        logic sa, sb, sx, sy, guard, sticky, found;
        logic [63:0] fa, fb, kept, fmask;
        logic [52:0] ma, mb, mx, my;
        logic [109:0] wx, wy, wsum, wnorm, rmask;
        ew    = exp_w(sz);
        fw    = frac_w(sz);
        p     = fw + 1;
        emax  = (1 << ew) - 1;
        fmask = (64'd1 << fw) - 64'd1;
        sa = a[ew + fw];
        sb = b[ew + fw];
        ea = int'((a >> fw) & 64'(emax));
        eb = int'((b >> fw) & 64'(emax));
        fa = a & fmask;
        fb = b & fmask;
        ma = {1'b1, 52'(fa << (52 - fw))};
        mb = {1'b1, 52'(fb << (52 - fw))};
        if ((ea == emax && fa != 0) || (eb == emax && fb != 0) ||
            (ea == emax && eb == emax && sa != sb))
            return fp_pack(sz, 1'b0, emax, 64'd1 << (fw - 1));
        if (ea == emax) return fp_pack(sz, sa, emax, 64'd0);
        if (eb == emax) return fp_pack(sz, sb, emax, 64'd0);
        if (ea == 0 && eb == 0) return fp_pack(sz, sa & sb, 0, 64'd0);
        if (ea == 0) return fp_pack(sz, sb, eb, fb);
        if (eb == 0) return fp_pack(sz, sa, ea, fa);
        if (eb > ea || (eb == ea && mb > ma)) begin
            sx = sb; ex = eb; mx = mb; sy = sa; ey = ea; my = ma;
        end else begin
            sx = sa; ex = ea; mx = ma; sy = sb; ey = eb; my = mb;
        end
        d  = ex - ey;
        wx = {1'b0, mx, 56'd0};
        wy = (d > 56) ? 110'd1 : ({1'b0, my, 56'd0} >> d);
        wsum = (sx == sy) ? (wx + wy) : (wx - wy);
        if (wsum == '0) return fp_pack(sz, 1'b0, 0, 64'd0);
        lz = 0;
        found = 1'b0;
        for (int i = 109; i >= 0; i--) begin
            if (!found) begin
                if (wsum[i]) found = 1'b1;
                else lz++;
            end
        end
        wnorm  = wsum << lz;
        er     = ex + 1 - lz;
        kept   = 64'(wnorm >> (110 - p));
        guard  = wnorm[109 - p];
        rmask  = (110'd1 << (109 - p)) - 110'd1;
        sticky = |(wnorm & rmask);
        if (guard && (sticky || kept[0])) kept = kept + 64'd1;
        if (kept[p]) begin
            kept = kept >> 1;
            er++;
        end
        if (er <= 0) return fp_pack(sz, sx, 0, 64'd0);
        if (er >= emax) return fp_pack(sz, sx, emax, 64'd0);
        return fp_pack(sz, sx, er, kept & fmask);
    endfunction

endpackage

// File: rtl/fold_req_check.sv
`timescale 1ns/1ps
// fold_req_check: decides whether a request may run and how many lanes the
// selected element size yields. Assumes VEC_W is a multiple of 128.
module fold_req_check #(
    parameter int VEC_W = 256,
    parameter int CNT_W = 5
) (
    input  logic [1:0]       size_i,
    input  logic             streaming_i,
    input  logic             fullfeat_i,
    output logic             legal_o,
    output logic [CNT_W-1:0] lanes_o
);
    import fold_pkg::*;

    // Legality: reserved size or streaming without full features rejects
    always_comb legal_o = (size_i != SZ_RSV) && !(streaming_i && !fullfeat_i);

    // Lane count: vector width over element width
    always_comb lanes_o = CNT_W'(VEC_W >> (32'(size_i) + 3));
endmodule

// File: rtl/fold_fp_add.sv
`timescale 1ns/1ps
// fold_fp_add: one combinational floating-point addition per cycle in the
// format chosen by the size code. Assumes size code is not reserved.
module fold_fp_add (
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    input  logic [1:0]  size_i,
    output logic [63:0] sum_o
);
    import fold_pkg::*;

    // Sum of the two operands, rounded and packed
    always_comb sum_o = fp_add(a_i, b_i, size_i);
endmodule

// File: rtl/ordered_fp_fold.sv
`timescale 1ns/1ps
// ordered_fp_fold: serial, strictly lane-ordered predicated floating-point
// reduction into a scalar. One lane is visited per cycle; the captured vector
// and predicate shift down so lane 0 is always at the bottom.
// Assumes VEC_W is a multiple of 128 (at least two double lanes).
module ordered_fp_fold #(
    parameter int VEC_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [63:0]        seed_i,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic [VEC_W/8-1:0] pred_i,
    input  logic [1:0]         size_i,
    input  logic               streaming_i,
    input  logic               fullfeat_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               illegal_o,
    output logic [63:0]        result_o
);
    import fold_pkg::*;

    localparam int PRED_W    = VEC_W / 8;
    localparam int MAX_LANES = VEC_W / 16;
    localparam int CNT_W     = $clog2(MAX_LANES + 1);

    logic               busy_q, done_q, illegal_q, legal;
    logic [63:0]        acc_q, sum, elem;
    logic [VEC_W-1:0]   vec_q;
    logic [PRED_W-1:0]  prd_q;
    logic [1:0]         size_q;
    logic [CNT_W-1:0]   left_q, lanes;
    logic [6:0]         esize;
    logic [3:0]         nbytes;

    fold_req_check #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chk_req (
        .size_i      (size_i),
        .streaming_i (streaming_i),
        .fullfeat_i  (fullfeat_i),
        .legal_o     (legal),
        .lanes_o     (lanes)
    );

    fold_fp_add u_add (
        .a_i    (acc_q),
        .b_i    (elem),
        .size_i (size_q),
        .sum_o  (sum)
    );

    // Current lane operand and shift amounts for the captured size
    always_comb begin
        elem   = vec_q[63:0] & elem_mask(size_q);
        esize  = 7'd8 << size_q;
        nbytes = 4'd1 << size_q;
    end

    // Request capture, per-lane accumulation and completion sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            acc_q     <= '0;
            vec_q     <= '0;
            prd_q     <= '0;
            size_q    <= SZ_D;
            left_q    <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    if (legal) begin
                        busy_q <= 1'b1;
                        acc_q  <= seed_i & elem_mask(size_i);
                        vec_q  <= vec_i;
                        prd_q  <= pred_i;
                        size_q <= size_i;
                        left_q <= lanes;
                    end else begin
                        illegal_q <= 1'b1;
                    end
                end
            end else begin
                if (prd_q[0]) acc_q <= sum;
                vec_q  <= vec_q >> esize;
                prd_q  <= prd_q >> nbytes;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Output drive from registered state
    always_comb begin
        busy_o    = busy_q;
        done_o    = done_q;
        illegal_o = illegal_q;
        result_o  = acc_q;
    end
endmodule

// File: rtl/fold_checker.sv
`timescale 1ns/1ps
// fold_checker: protocol properties of ordered_fp_fold, observed at its ports.
module fold_checker #(
    parameter int VEC_W = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [1:0]         size_i,
    input logic               streaming_i,
    input logic               fullfeat_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               illegal_o,
    input logic [63:0]        result_o
);
    // Reserved size code is rejected
    assert_reserved_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && size_i == 2'b00) |=> (illegal_o && !busy_o));

    // Rejection leaves the result untouched
    assert_reject_keeps_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && size_i == 2'b00) |=> $stable(result_o));

    // Streaming without full features is rejected
    assert_streaming_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && streaming_i && !fullfeat_i) |=> illegal_o);

    // A legal request starts the fold
    assert_legal_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && size_i != 2'b00 && !(streaming_i && !fullfeat_i)) |=> busy_o);

    // Completion follows a busy cycle and ends it
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // Completion and rejection never coincide
    assert_done_illegal_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o));

    // Result only changes while folding
    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(start_i && size_i != 2'b00 && !(streaming_i && !fullfeat_i)))
        |=> $stable(result_o));
endmodule

bind ordered_fp_fold fold_checker #(.VEC_W(VEC_W)) u_fold_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .size_i      (size_i),
    .streaming_i (streaming_i),
    .fullfeat_i  (fullfeat_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .result_o    (result_o)
);

// File: tb/sim_ordered_fp_fold.sv
`timescale 1ns/1ps
module sim_ordered_fp_fold;
    localparam int VW = 128;
    localparam int PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [63:0]   seed_i = '0;
    logic [VW-1:0] vec_i = '0;
    logic [PW-1:0] pred_i = '0;
    logic [1:0]    size_i = 2'b01;
    logic          streaming_i = 1'b0;
    logic          fullfeat_i = 1'b0;
    logic          busy_o, done_o, illegal_o;
    logic [63:0]   result_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    ordered_fp_fold #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i), .vec_i(vec_i),
        .pred_i(pred_i), .size_i(size_i), .streaming_i(streaming_i), .fullfeat_i(fullfeat_i),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                total++; bad++;
                $display("FAIL watchdog R7 act=%0d exp<190000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int ewf(input int sz); return sz == 1 ? 5 : sz == 2 ? 8 : 11; endfunction
    function automatic int fwf(input int sz); return sz == 1 ? 10 : sz == 2 ? 23 : 52; endfunction
    function automatic int biasf(input int sz); return (1 << (ewf(sz) - 1)) - 1; endfunction
    function automatic logic [63:0] maskf(input int sz);
        return sz == 3 ? {64{1'b1}} : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    function automatic logic [63:0] mk(input int sz, input logic s, input int e, input logic [63:0] f);
        return (64'(s) << (ewf(sz) + fwf(sz))) | (64'(e) << fwf(sz)) | f;
    endfunction

    function automatic logic [63:0] qnan(input int sz);
        return mk(sz, 1'b0, (1 << ewf(sz)) - 1, 64'd1 << (fwf(sz) - 1));
    endfunction

    // Format value to binary64 bits, zero exponent flushed to signed zero
    function automatic logic [63:0] widen(input logic [63:0] x, input int sz);
        int fw, e, emax;
        logic s;
        logic [63:0] f;
        fw = fwf(sz);
        emax = (1 << ewf(sz)) - 1;
        s = x[ewf(sz) + fw];
        e = int'((x >> fw) & 64'(emax));
        f = x & ((64'd1 << fw) - 64'd1);
        if (e == 0) return {s, 63'd0};
        if (e == emax) return {s, 11'h7FF, (f != 0) ? {1'b1, 51'd0} : 52'd0};
        return {s, 11'(e - biasf(sz) + 1023), 52'(f << (52 - fw))};
    endfunction

    // binary64 bits to format with round-to-nearest-even and flush-to-zero
    function automatic logic [63:0] narrow(input logic [63:0] d, input int sz);
        int p, emax, be;
        logic s, g, st;
        logic [52:0] sig;
        logic [63:0] kept;
        s = d[63];
        emax = (1 << ewf(sz)) - 1;
        if (d[62:52] == 0) return mk(sz, s, 0, 0);
        if (d[62:52] == 11'h7FF) return mk(sz, s, emax, 0);
        if (sz == 3) return d;
        p = fwf(sz) + 1;
        sig = {1'b1, d[51:0]};
        kept = 64'(sig >> (53 - p));
        g = sig[52 - p];
        st = |(sig & ((53'd1 << (52 - p)) - 53'd1));
        be = int'(d[62:52]) - 1023 + biasf(sz);
        if (g && (st || kept[0])) kept++;
        if (kept[p]) begin kept = kept >> 1; be++; end
        if (be <= 0) return mk(sz, s, 0, 0);
        if (be >= emax) return mk(sz, s, emax, 0);
        return mk(sz, s, be, kept & ((64'd1 << fwf(sz)) - 64'd1));
    endfunction

    function automatic logic [63:0] ref_add(input logic [63:0] a, input logic [63:0] b, input int sz);
        logic [63:0] da, db;
        real r;
        da = widen(a, sz);
        db = widen(b, sz);
        if ((da[62:52] == 11'h7FF && da[51:0] != 0) || (db[62:52] == 11'h7FF && db[51:0] != 0))
            return qnan(sz);
        if (da[62:52] == 11'h7FF && db[62:52] == 11'h7FF && da[63] != db[63]) return qnan(sz);
        if (da[62:52] == 11'h7FF) return narrow(da, sz);
        if (db[62:52] == 11'h7FF) return narrow(db, sz);
        r = $bitstoreal(da) + $bitstoreal(db);
        return narrow($realtobits(r), sz);
    endfunction

    function automatic logic [63:0] ref_fold(input int sz, input logic [63:0] seed,
                                             input logic [VW-1:0] v, input logic [PW-1:0] pr);
        logic [63:0] acc;
        int w;
        w = 8 << sz;
        acc = seed & maskf(sz);
        for (int k = 0; k < VW / w; k++)
            if (pr[k * (w / 8)]) acc = ref_add(acc, 64'(v >> (k * w)) & maskf(sz), sz);
        return acc;
    endfunction

    function automatic logic [63:0] rnd_val(input int sz);
        int b;
        logic [63:0] f;
        b = biasf(sz);
        f = {$urandom, $urandom} & ((64'd1 << fwf(sz)) - 64'd1);
        return mk(sz, 1'($urandom % 2), b - 8 + int'($urandom % 17), f);
    endfunction

    function automatic logic [VW-1:0] put_lane(input logic [VW-1:0] v, input int sz, input int k,
                                               input logic [63:0] x);
        logic [VW-1:0] m;
        m = VW'(maskf(sz)) << (k * (8 << sz));
        return (v & ~m) | ((VW'(x & maskf(sz))) << (k * (8 << sz)));
    endfunction

    // Issue one legal fold, check latency and result
    task automatic run_fold(input int sz, input logic [63:0] seed, input logic [VW-1:0] v,
                            input logic [PW-1:0] pr, input string tag, input logic poke_busy);
        logic [63:0] exp;
        int n, waited;
        exp = ref_fold(sz, seed, v, pr);
        n = VW / (8 << sz);
        @(negedge clk);
        start_i = 1'b1; size_i = 2'(sz); seed_i = seed; vec_i = v; pred_i = pr;
        @(negedge clk);
        start_i = 1'b0;
        if (!busy_o) check(1'b0, {tag, " R7 busy after start"}, 64'(busy_o), 64'd1);
        if (poke_busy) begin
            start_i = 1'b1; size_i = 2'b00; seed_i = ~seed; vec_i = ~v; pred_i = ~pr;
            @(negedge clk);
            start_i = 1'b0; size_i = 2'(sz);
            waited = 1;
        end else waited = 0;
        while (!done_o && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(waited == n, {tag, " R7 latency"}, 64'(waited), 64'(n));
        check(result_o == exp, {tag, " R5 result"}, result_o, exp);
    endtask

    // Issue a request expected to be rejected
    task automatic run_reject(input logic [1:0] sz, input logic strm, input logic ff, input string tag);
        logic [63:0] held;
        held = result_o;
        @(negedge clk);
        start_i = 1'b1; size_i = sz; streaming_i = strm; fullfeat_i = ff; seed_i = 64'h1234;
        @(negedge clk);
        start_i = 1'b0;
        check(illegal_o && !busy_o, {tag, " illegal pulse"}, {62'd0, illegal_o, busy_o}, 64'd2);
        check(result_o == held, {tag, " R10 result held"}, result_o, held);
        @(negedge clk);
        check(!illegal_o, {tag, " illegal one cycle"}, 64'(illegal_o), 64'd0);
        streaming_i = 1'b0; fullfeat_i = 1'b0;
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [PW-1:0] pr;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !illegal_o && result_o == 0, "R7 reset state",
              {busy_o, done_o, illegal_o, 61'(result_o)}, 64'd0);
        rst_n = 1'b1;

        // Sweep every lane mask for each size; junk in non-lane predicate bits (R4)
        for (int sz = 1; sz <= 3; sz++) begin
            int n;
            n = VW / (8 << sz);
            for (int m = 0; m < (1 << n); m++) begin
                v = '0;
                for (int k = 0; k < n; k++) v = put_lane(v, sz, k, rnd_val(sz));
                pr = PW'({$urandom, $urandom, $urandom, $urandom});
                for (int k = 0; k < n; k++) pr[k * (1 << sz)] = m[k];
                run_fold(sz, rnd_val(sz) | 64'hFFFF_0000_0000_0000, v, pr, "R1 R4 sweep", 1'b0);
            end
        end

        // R6: no active lane keeps a non-canonical NaN seed; other bits set
        run_fold(1, 64'h7D01, {VW{1'b1}}, 16'hAAAA, "R6 no active", 1'b0);
        check(result_o == 64'h7D01, "R6 seed untouched", result_o, 64'h7D01);

        // R8: subnormal seed treated as zero; negative subnormal difference flushes
        v = put_lane('0, 2, 0, 64'h3F80_0000);
        run_fold(2, 64'h0000_0001, v, 16'h0001, "R8 subnormal in", 1'b0);
        check(result_o == 64'h3F80_0000, "R8 subnormal seed", result_o, 64'h3F80_0000);
        v = put_lane('0, 2, 0, 64'h8080_0001);
        run_fold(2, 64'h0080_0000, v, 16'h0001, "R8 underflow", 1'b0);
        check(result_o == 64'h8000_0000, "R8 signed zero", result_o, 64'h8000_0000);

        // R9: overflow, inf minus inf, NaN lane
        v = put_lane('0, 1, 0, 64'h7BFF);
        run_fold(1, 64'h7BFF, v, 16'h0001, "R9 overflow", 1'b0);
        check(result_o == 64'h7C00, "R9 overflow inf", result_o, 64'h7C00);
        v = put_lane(put_lane('0, 3, 0, 64'hFFF0_0000_0000_0000), 3, 1, 64'h3FF0_0000_0000_0000);
        run_fold(3, 64'h7FF0_0000_0000_0000, v, 16'h0101, "R9 inf-inf", 1'b0);
        check(result_o == 64'h7FF8_0000_0000_0000, "R9 canonical qnan", result_o, 64'h7FF8_0000_0000_0000);
        v = put_lane('0, 2, 3, 64'hFF80_0123);
        run_fold(2, 64'h3F80_0000, v, 16'h1000, "R9 nan lane", 1'b0);
        check(result_o == 64'h7FC0_0000, "R9 nan canonical", result_o, 64'h7FC0_0000);

        // R5: order matters: 1 + 2^-11 + 2^-11 in half (ties to even each step)
        v = put_lane(put_lane('0, 1, 0, 64'h1000), 1, 1, 64'h1000);
        run_fold(1, 64'h3C00, v, 16'h0005, "R5 order", 1'b0);
        check(result_o == 64'h3C00, "R5 serial rounding", result_o, 64'h3C00);

        // R7: start while busy is ignored
        v = put_lane(put_lane('0, 3, 0, 64'h4000_0000_0000_0000), 3, 1, 64'h4008_0000_0000_0000);
        run_fold(3, 64'h3FF0_0000_0000_0000, v, 16'hFFFF, "R7 start while busy", 1'b1);
        check(result_o == 64'h4018_0000_0000_0000, "R7 ignored restart", result_o, 64'h4018_0000_0000_0000);

        // R2, R3 rejections; R10 hold across idle
        run_reject(2'b00, 1'b0, 1'b0, "R2 reserved size");
        run_reject(2'b10, 1'b1, 1'b0, "R3 streaming");
        repeat (5) @(negedge clk);
        check(result_o == 64'h4018_0000_0000_0000, "R10 idle hold", result_o, 64'h4018_0000_0000_0000);
        streaming_i = 1'b1; fullfeat_i = 1'b1;
        v = put_lane('0, 2, 1, 64'h4000_0000);
        run_fold(2, 64'h3F80_0000, v, 16'h0010, "R3 streaming full", 1'b0);
        check(result_o == 64'h4040_0000, "R3 legal streaming", result_o, 64'h4040_0000);
        streaming_i = 1'b0; fullfeat_i = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule